// File: doc/BRIEF.md
# Timer Compare/Capture Output Channel

This block is one compare/capture channel of a 16-bit timer. It works beside a neighbour channel and receives the value of a shared counter. The counter and the bus interface sit outside the block. The channel has one data register, and a mode bit decides what that register does.

In comparator mode the register holds a compare value. The channel raises a one-clock match strobe when the counter equals that value. The strobe then drives a small output state machine, which makes the timer output waveform. In capture mode the register instead takes a copy of the counter value each time a capture trigger arrives, and the output is frozen.

The output state machine has two states, `LVL_OFF` (output inactive) and `LVL_ON` (output active). Five waveform modes are decoded into set, clear and toggle events:
- software level
- set
- toggle with clear
- set with clear
- pure toggle

A pairing bit selects where the events come from. When the bit is clear, the channel uses only its own match, and the clear event is the counter-direction end event. When the bit is set, the neighbour's match acts as the clear event, or as an extra set or toggle event, depending on the mode.

The transitions are:
- `LVL_OFF -> LVL_ON` on a set event, on a toggle, or when the software bit is 1 in software mode.
- `LVL_ON -> LVL_OFF` on a clear event, on a toggle, or when the software bit is 0 in software mode.
- Each state holds when no event arrives, when capture mode is on, or when the mode code is unused.

A polarity bit inverts the pin, but only in comparator mode.

Top module: `tcc_channel`

## Requirements
- R1: During and after reset, `cc_data` is 0, `match` is 0 and the level is `LVL_OFF`. As a result, `tout` equals `cfg_invert & ~cfg_capture`.
- R2: In comparator mode (`cfg_capture`=0), a clock edge with `wr_en`=1 loads `wr_data` into the register, and `cc_data` shows it from the next cycle. In capture mode `wr_en` has no effect on `cc_data`.
- R3: `match` is high for the one cycle after each clock edge at which `cfg_capture`=0 and `cnt_val` equalled the register. It is never high after an edge taken in capture mode.
- R4: In capture mode, a clock edge with `cap_trig`=1 copies `cnt_val` into `cc_data`. In comparator mode `cap_trig` has no effect on `cc_data`.
- R5: Output mode code 0 (software) sets the level at each edge to `cfg_sw_out`, with 1 meaning `LVL_ON`.
- R6: Mode code 1 (set) moves the level to `LVL_ON` at an edge where `match` is high. When `cfg_paired`=1, `peer_match` has the same effect.
- R7: Mode code 4 (toggle) inverts the level at an edge where `match` is high. When `cfg_paired`=1, the level also inverts when `peer_match` is high, and it inverts only once if both are high.
- R8: Mode code 3 (set/clear) with `cfg_paired`=0 sets the level on `match`. It clears the level on `evt_max` when `cfg_cnt_dir`=0 (up), and on `evt_zero` when `cfg_cnt_dir` is 1 (up/down) or 2 (down).
- R9: Mode code 2 (toggle/clear) with `cfg_paired`=0 inverts the level on `match`. It clears the level on the same direction end event as R8.
- R10: With `cfg_paired`=1, modes 2 and 3 use `peer_match` as the clear event, and the direction end events are ignored.
- R11: When a clear event and a set or toggle event fall on the same edge, the level ends in `LVL_OFF`.
- R12: In comparator mode `tout` is the level XOR `cfg_invert`, so `cfg_invert`=1 makes the output active-low. In capture mode `tout` equals the level whatever the value of `cfg_invert`.
- R13: In capture mode the level holds, whatever the events. Mode codes 5 to 7 also hold the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | W | Shared counter value |
| cfg_cnt_dir | input | 2 | Count mode: 0 up, 1 up/down, 2 down |
| evt_max | input | 1 | Counter reached its maximum (strobe) |
| evt_zero | input | 1 | Counter reached zero (strobe) |
| peer_match | input | 1 | Match strobe of the neighbour channel |
| cap_trig | input | 1 | Capture trigger |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | W | Register write value |
| cfg_capture | input | 1 | 1 capture mode, 0 comparator mode |
| cfg_outmode | input | 3 | Output waveform mode code |
| cfg_paired | input | 1 | Use neighbour match as well |
| cfg_invert | input | 1 | Output polarity, 1 active-low |
| cfg_sw_out | input | 1 | Software level for mode 0 |
| match | output | 1 | Match strobe |
| tout | output | 1 | Timer output pin |
| cc_data | output | W | Compare / captured value |

## Verification
Writes and captures reach `cc_data` one clock edge after they are presented. The match strobe appears one edge after `cnt_val` equals the register. The output level moves one edge after the strobes and events it reacts to, so it lags the counter compare by two edges. The polarity and capture-mode gating of `tout` are combinational and take effect at once.

The bench drives all inputs just after a falling edge and steps a reference model at each rising edge. It compares `match`, `cc_data` and `tout` at the next falling edge, so every result is sampled in the cycle in which it is due.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OM_SOFT   = 3'd0,
        OM_SET    = 3'd1,
        OM_TOGCLR = 3'd2,
        OM_SETCLR = 3'd3,
        OM_TOGGLE = 3'd4
    } outmode_e;

    typedef enum logic [1:0] {
        DIR_UP     = 2'd0,
        DIR_UPDOWN = 2'd1,
        DIR_DOWN   = 2'd2
    } cntdir_e;

    typedef enum logic {
        LVL_OFF = 1'b0,
        LVL_ON  = 1'b1
    } level_e;

    typedef struct packed {
        logic sw_ctl;
        logic sw_val;
        logic set_ev;
        logic clr_ev;
        logic tog_ev;
    } out_events_t;

endpackage

// File: rtl/tcc_ccreg.sv
module tcc_ccreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_mode,
    input  logic         cap_trig,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt_val,
    output logic [W-1:0] cc_q,
    output logic         match_q
);
    localparam logic [W-1:0] REG_INIT = '0;

    logic [W-1:0] cc_next;
    logic         hit;

    // Register source depends on the channel mode.
    always_comb begin
        cc_next = cc_q;
        if (capture_mode) begin
            if (cap_trig) cc_next = cnt_val;
        end else begin
            if (wr_en) cc_next = wr_data;
        end
    end

    assign hit = !capture_mode && (cnt_val == cc_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q    <= REG_INIT;
            match_q <= 1'b0;
        end else begin
            cc_q    <= cc_next;
            match_q <= hit;
        end
    end

endmodule

// File: rtl/tcc_event_decode.sv
module tcc_event_decode
    import tcc_pkg::*;
(
    input  logic        [2:0] mode,
    input  logic              paired,
    input  logic        [1:0] cnt_dir,
    input  logic              own_match,
    input  logic              peer_match,
    input  logic              evt_max,
    input  logic              evt_zero,
    input  logic              sw_out,
    output out_events_t       ev
);
    outmode_e om;
    logic     end_ev;
    logic     any_match;
    logic     clr_src;

    assign om        = outmode_e'(mode);
    // Up counting ends on MAX, the other count modes on ZERO.
    assign end_ev    = (cntdir_e'(cnt_dir) == DIR_UP) ? evt_max : evt_zero;
    assign any_match = own_match | (paired & peer_match);
    assign clr_src   = paired ? peer_match : end_ev;

    always_comb begin
        ev = '0;
        unique case (om)
            OM_SOFT: begin
                ev.sw_ctl = 1'b1;
                ev.sw_val = sw_out;
            end
            OM_SET: begin
                ev.set_ev = any_match;
            end
            OM_TOGCLR: begin
                ev.tog_ev = own_match;
                ev.clr_ev = clr_src;
            end
            OM_SETCLR: begin
                ev.set_ev = own_match;
                ev.clr_ev = clr_src;
            end
            OM_TOGGLE: begin
                ev.tog_ev = any_match;
            end
            default: ev = '0;
        endcase
    end

endmodule

// File: rtl/tcc_out_fsm.sv
module tcc_out_fsm
    import tcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        freeze,
    input  out_events_t ev,
    output logic        active
);
    level_e state_q;
    level_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_OFF;
        else        state_q <= state_d;
    end

    // Priority: freeze, software, clear, set, toggle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_OFF: begin
                if (freeze)                       state_d = LVL_OFF;
                else if (ev.sw_ctl)               state_d = ev.sw_val ? LVL_ON : LVL_OFF;
                else if (ev.clr_ev)               state_d = LVL_OFF;
                else if (ev.set_ev || ev.tog_ev)  state_d = LVL_ON;
            end
            LVL_ON: begin
                if (freeze)                       state_d = LVL_ON;
                else if (ev.sw_ctl)               state_d = ev.sw_val ? LVL_ON : LVL_OFF;
                else if (ev.clr_ev)               state_d = LVL_OFF;
                else if (ev.set_ev)               state_d = LVL_ON;
                else if (ev.tog_ev)               state_d = LVL_OFF;
            end
            default: state_d = LVL_OFF;
        endcase
    end

    always_comb begin
        active = (state_q == LVL_ON);
    end

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_val,
    input  logic [1:0]   cfg_cnt_dir,
    input  logic         evt_max,
    input  logic         evt_zero,
    input  logic         peer_match,
    input  logic         cap_trig,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cfg_capture,
    input  logic [2:0]   cfg_outmode,
    input  logic         cfg_paired,
    input  logic         cfg_invert,
    input  logic         cfg_sw_out,
    output logic         match,
    output logic         tout,
    output logic [W-1:0] cc_data
);
    out_events_t ev;
    logic        lvl_active;

    tcc_ccreg #(.W(W)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_mode (cfg_capture),
        .cap_trig     (cap_trig),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cnt_val      (cnt_val),
        .cc_q         (cc_data),
        .match_q      (match)
    );

    tcc_event_decode u_dec (
        .mode       (cfg_outmode),
        .paired     (cfg_paired),
        .cnt_dir    (cfg_cnt_dir),
        .own_match  (match),
        .peer_match (peer_match),
        .evt_max    (evt_max),
        .evt_zero   (evt_zero),
        .sw_out     (cfg_sw_out),
        .ev         (ev)
    );

    tcc_out_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (cfg_capture),
        .ev     (ev),
        .active (lvl_active)
    );

    // Polarity only applies in comparator mode.
    assign tout = lvl_active ^ (cfg_invert & ~cfg_capture);

endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_val,
    input logic [1:0]   cfg_cnt_dir,
    input logic         evt_max,
    input logic         cap_trig,
    input logic         cfg_capture,
    input logic [2:0]   cfg_outmode,
    input logic         cfg_paired,
    input logic         cfg_invert,
    input logic         cfg_sw_out,
    input logic         match,
    input logic         tout,
    input logic [W-1:0] cc_data
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_match_equal_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        match |-> $past(cnt_val == cc_data));

    p_no_match_capture_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cfg_capture) |-> !match);

    p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cfg_capture && cap_trig) |-> cc_data == $past(cnt_val));

    p_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cfg_capture && !cap_trig) |-> $stable(cc_data));

    p_sw_follow_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(!cfg_capture && cfg_outmode == 3'd0) && !cfg_capture)
            |-> tout == ($past(cfg_sw_out) ^ cfg_invert));

    p_capture_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(cfg_capture) && cfg_capture) |-> $stable(tout));

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(!cfg_capture && cfg_outmode == 3'd3 && !cfg_paired
               && cfg_cnt_dir == 2'd0 && evt_max) && !cfg_capture)
            |-> tout == cfg_invert);

endmodule

bind tcc_channel tcc_channel_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .cfg_cnt_dir (cfg_cnt_dir),
    .evt_max     (evt_max),
    .cap_trig    (cap_trig),
    .cfg_capture (cfg_capture),
    .cfg_outmode (cfg_outmode),
    .cfg_paired  (cfg_paired),
    .cfg_invert  (cfg_invert),
    .cfg_sw_out  (cfg_sw_out),
    .match       (match),
    .tout        (tout),
    .cc_data     (cc_data)
);

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] cnt_val;
    logic [1:0]   cfg_cnt_dir;
    logic         evt_max, evt_zero, peer_match, cap_trig, wr_en;
    logic [W-1:0] wr_data;
    logic         cfg_capture, cfg_paired, cfg_invert, cfg_sw_out;
    logic [2:0]   cfg_outmode;
    logic         match, tout;
    logic [W-1:0] cc_data;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [W-1:0] m_reg;
    logic         m_match;
    logic         m_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcc_channel #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cfg_cnt_dir(cfg_cnt_dir),
        .evt_max(evt_max), .evt_zero(evt_zero), .peer_match(peer_match),
        .cap_trig(cap_trig), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_capture(cfg_capture), .cfg_outmode(cfg_outmode), .cfg_paired(cfg_paired),
        .cfg_invert(cfg_invert), .cfg_sw_out(cfg_sw_out),
        .match(match), .tout(tout), .cc_data(cc_data)
    );

    function automatic logic lvl_next(logic lvl);
        logic endev, s, c, t;
        endev = (cfg_cnt_dir == 2'd0) ? evt_max : evt_zero;
        s = 1'b0; c = 1'b0; t = 1'b0;
        if (cfg_capture) return lvl;
        case (cfg_outmode)
            3'd0: return cfg_sw_out;
            3'd1: s = m_match | (cfg_paired & peer_match);
            3'd2: begin t = m_match; c = cfg_paired ? peer_match : endev; end
            3'd3: begin s = m_match; c = cfg_paired ? peer_match : endev; end
            3'd4: t = m_match | (cfg_paired & peer_match);
            default: return lvl;
        endcase
        if (c) return 1'b0;
        if (s) return 1'b1;
        if (t) return ~lvl;
        return lvl;
    endfunction

    function automatic string tout_tag();
        if (cfg_capture) return "R13";
        case (cfg_outmode)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return cfg_paired ? "R10" : "R9";
            3'd3: return cfg_paired ? "R10" : "R8";
            3'd4: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 match", {{(W-1){1'b0}}, match}, {{(W-1){1'b0}}, m_match});
        check(cfg_capture ? "R4 cc_data" : "R2 cc_data", cc_data, m_reg);
        check({tout_tag(), "/R12 tout"}, {{(W-1){1'b0}}, tout},
              {{(W-1){1'b0}}, m_level ^ (cfg_invert & ~cfg_capture)});
    endtask

    // Step one edge: model computes from driven inputs, then compare at negedge.
    task automatic tick();
        logic [W-1:0] n_reg;
        logic n_match, n_lvl;
        n_match = !cfg_capture && (cnt_val == m_reg);
        n_reg   = cfg_capture ? (cap_trig ? cnt_val : m_reg) : (wr_en ? wr_data : m_reg);
        n_lvl   = lvl_next(m_level);
        @(posedge clk);
        m_reg = n_reg; m_match = n_match; m_level = n_lvl;
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_strobes();
        evt_max = 0; evt_zero = 0; peer_match = 0; cap_trig = 0; wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; cnt_val = 0; cfg_cnt_dir = 0; wr_data = 0;
        cfg_capture = 0; cfg_outmode = 3'd3; cfg_paired = 0; cfg_invert = 1; cfg_sw_out = 1;
        clear_strobes();
        m_reg = 0; m_match = 0; m_level = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, active-low polarity -> pin high
        check("R1 cc_data", cc_data, '0);
        check("R1 match", {{(W-1){1'b0}}, match}, '0);
        check("R1 tout", {{(W-1){1'b0}}, tout}, {{(W-1){1'b0}}, 1'b1});
        rst_n = 1; cfg_invert = 0;

        // R11: match and MAX on the same edge in set/clear, up count
        cnt_val = 7; wr_en = 1; wr_data = 3; tick();
        wr_en = 0; cnt_val = 3; tick();
        check("R3 match directed", {{(W-1){1'b0}}, match}, {{(W-1){1'b0}}, 1'b1});
        cnt_val = 7; evt_max = 1; tick();
        check("R11 clear beats set", {{(W-1){1'b0}}, tout}, '0);
        evt_max = 0;

        // R12: set mode, drive level on, then flip polarity and capture mode
        cfg_outmode = 3'd1; cnt_val = 3; tick();
        cnt_val = 7; tick();
        check("R12 active high", {{(W-1){1'b0}}, tout}, {{(W-1){1'b0}}, 1'b1});
        cfg_invert = 1; #1;
        check("R12 active low", {{(W-1){1'b0}}, tout}, '0);
        cfg_capture = 1; #1;
        check("R12 no invert in capture", {{(W-1){1'b0}}, tout}, {{(W-1){1'b0}}, 1'b1});
        // R13/R4: capture mode freezes the level; write ignored, trigger loads
        cfg_outmode = 3'd0; cfg_sw_out = 0; wr_en = 1; wr_data = 5; tick();
        check("R13 hold in capture", {{(W-1){1'b0}}, tout}, {{(W-1){1'b0}}, 1'b1});
        check("R2 write ignored in capture", cc_data, 16'd3);
        wr_en = 0; cap_trig = 1; cnt_val = 16'h1234; tick();
        check("R4 capture loads", cc_data, 16'h1234);
        cap_trig = 0; cfg_capture = 0; cfg_invert = 0; tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (i % 40 == 0) begin
                cfg_outmode = 3'($urandom_range(0, 5));
                cfg_paired  = 1'($urandom_range(0, 1));
                cfg_cnt_dir = 2'($urandom_range(0, 2));
                cfg_invert  = 1'($urandom_range(0, 1));
                cfg_capture = ($urandom_range(0, 3) == 0);
            end
            cnt_val    = W'($urandom_range(0, 5));
            evt_max    = ($urandom_range(0, 5) == 0);
            evt_zero   = ($urandom_range(0, 5) == 0);
            peer_match = ($urandom_range(0, 4) == 0);
            cap_trig   = ($urandom_range(0, 7) == 0);
            wr_en      = ($urandom_range(0, 9) == 0);
            wr_data    = W'($urandom_range(0, 5));
            if ($urandom_range(0, 2) == 0) cfg_sw_out = ~cfg_sw_out;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule